// File: doc/BRIEF.md
# Posit Operand Field Decoder

This block is purely combinational. It takes one posit-encoded word of `NBITS` bits with `ES` exponent bits and splits it into the pieces that later arithmetic stages need. Those pieces are a sign, a regime value, an exponent, a signed scale and a fraction that carries its hidden one explicitly. It also flags the two special codes: zero and Not-a-Real (NaR).

The regime is a run-length field of variable size. Because of this, the positions of the exponent and the fraction move with every input. The decoder first takes the two's complement of a negative word. It then measures the run at the top of the remaining bits and shifts past the run and its terminating bit. The exponent and fraction are read from the bits that follow. The outputs are meant to feed an adder, multiplier or divider datapath in the same cycle.

Top module: `posit_field_decode`

## Requirements
- R1: `zero_o` is 1 only for the all-zero word; while it is 1, `sign_o`, `regime_o`, `exp_o`, `scale_o` and `frac_o` are all 0.
- R2: `nar_o` is 1 only for the word whose MSB is 1 and whose other bits are 0; while it is 1, `sign_o` is 1 and `regime_o`, `exp_o`, `scale_o` and `frac_o` are 0. `zero_o` and `nar_o` are never 1 together.
- R3: `sign_o` equals the input MSB. A negative input is decoded from its two's complement, so a nonzero word x and its negation give identical regime, exponent, scale and fraction outputs.
- R4: Let L be the length of the run of identical bits that starts just below the sign. The run ends at the first opposite bit or at the end of the word. `regime_o` (signed) is L-1 for a run of ones and -L for a run of zeros.
- R5: `exp_o` holds the `ES` bits that follow the run's terminating bit. Bit positions beyond the end of the word read as 0.
- R6: `scale_o` (signed, `regime_o` width plus `ES` bits) equals `regime_o`·2^ES + `exp_o` for every non-special word.
- R7: `frac_o` is `NBITS-ES-2` bits wide. Its MSB is a 1 for every non-special word. Below that MSB, the fraction bits that remain after the exponent are placed left-aligned, and missing positions are filled with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| posit_i | input | NBITS | Posit word to decode |
| sign_o | output | 1 | Sign of the word |
| zero_o | output | 1 | Word is the zero code |
| nar_o | output | 1 | Word is the NaR code |
| regime_o | output | $clog2(NBITS)+1 | Signed regime value k |
| exp_o | output | ES | Exponent field, truncated bits as 0 |
| scale_o | output | $clog2(NBITS)+1+ES | Signed scale k·2^ES + exponent |
| frac_o | output | NBITS-ES-2 | Fraction with explicit leading one |

## Verification
The checker evaluates its properties whenever the outputs change. It assumes `posit_i` carries a fully known two-state value, because an unknown bit would make the run scan, and therefore every property, meaningless. The stimulus drives only defined 8-bit codes: a table of hand-decoded words, an exhaustive sweep of all 256 codes for the flags and the hidden bit, and a pairing of every positive code with its negation. These together cover the extreme regimes, where the exponent and fraction are cut off entirely.

// File: rtl/posit_dec_pkg.sv
`timescale 1ns/1ps
package posit_dec_pkg;
   // signed regime value: covers -(n-1) .. n-2
   function automatic int regime_w(input int n);
      return $clog2(n) + 1;
   endfunction
   // fraction bits below the hidden one
   function automatic int frac_w(input int n, input int es);
      return n - 3 - es;
   endfunction
   function automatic int scale_w(input int n, input int es);
      return regime_w(n) + es;
   endfunction
   // shift past run and terminator: 1 .. n
   function automatic int shamt_w(input int n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/posit_sign_cond.sv
`timescale 1ns/1ps
module posit_sign_cond #(
   parameter int NBITS = 8
) (
   input  logic [NBITS-1:0] word_i,
   output logic             neg_o,
   output logic [NBITS-2:0] body_o,
   output logic             zero_o,
   output logic             nar_o
);
   localparam int BW = NBITS - 1;

   logic tail_clear;

   assign neg_o      = word_i[NBITS-1];
   assign tail_clear = ~|word_i[BW-1:0];
   // magnitude of any non-NaR word fits below the sign bit
   assign body_o     = neg_o ? (~word_i[BW-1:0] + BW'(1)) : word_i[BW-1:0];
   assign zero_o     = !neg_o && tail_clear;
   assign nar_o      = neg_o && tail_clear;
endmodule

// File: rtl/posit_regime_scan.sv
`timescale 1ns/1ps
module posit_regime_scan
   import posit_dec_pkg::*;
#(
   parameter int NBITS = 8
) (
   input  logic [NBITS-2:0]                    body_i,
   output logic signed [regime_w(NBITS)-1:0]   regime_o,
   output logic [shamt_w(NBITS)-1:0]           shamt_o
);
   localparam int BW = NBITS - 1;
   localparam int RW = regime_w(NBITS);
   localparam int AW = shamt_w(NBITS);

   int   run;
   logic ended;

   always_comb begin
      run   = 0;
      ended = 1'b0;
      for (int i = BW - 1; i >= 0; i--) begin
         if (!ended) begin
            if (body_i[i] == body_i[BW-1]) run = run + 1;
            else                            ended = 1'b1;
         end
      end
      regime_o = body_i[BW-1] ? RW'(run - 1) : RW'(-run);
      shamt_o  = AW'(run + 1);
   end
endmodule

// File: rtl/posit_field_align.sv
`timescale 1ns/1ps
module posit_field_align
   import posit_dec_pkg::*;
#(
   parameter int NBITS = 8,
   parameter int ES    = 1
) (
   input  logic [NBITS-3:0]          tail_i,
   input  logic [shamt_w(NBITS)-1:0] shamt_i,
   output logic [ES-1:0]             exp_o,
   output logic [frac_w(NBITS,ES):0] frac_o
);
   localparam int BW = NBITS - 1;
   localparam int FW = frac_w(NBITS, ES);
   localparam int XW = ES + FW;

   logic [XW-1:0] fields;
   int            idx;

   // bits after the terminator, zero-filled past the word end
   always_comb begin
      fields = '0;
      idx    = 0;
      for (int j = 0; j < XW; j++) begin
         idx = BW - 1 - int'(shamt_i) - j;
         if (idx >= 0) fields[XW-1-j] = tail_i[idx];
      end
   end

   assign exp_o = fields[XW-1 -: ES];

   generate
      if (FW > 0) begin : g_frac_bits
         assign frac_o = {1'b1, fields[FW-1:0]};
      end else begin : g_frac_none
         assign frac_o = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/posit_field_decode.sv
`timescale 1ns/1ps
module posit_field_decode
   import posit_dec_pkg::*;
#(
   parameter int NBITS = 8,
   parameter int ES    = 1
) (
   input  logic [NBITS-1:0]                       posit_i,
   output logic                                   sign_o,
   output logic                                   zero_o,
   output logic                                   nar_o,
   output logic signed [regime_w(NBITS)-1:0]      regime_o,
   output logic [ES-1:0]                          exp_o,
   output logic signed [scale_w(NBITS,ES)-1:0]    scale_o,
   output logic [frac_w(NBITS,ES):0]              frac_o
);
   localparam int BW = NBITS - 1;
   localparam int RW = regime_w(NBITS);
   localparam int FW = frac_w(NBITS, ES);
   localparam int AW = shamt_w(NBITS);

   generate
      if (ES < 1) begin : g_bad_es
         $error("posit_field_decode: ES must be at least 1");
      end
      if (NBITS < ES + 3) begin : g_bad_width
         $error("posit_field_decode: NBITS must be at least ES+3");
      end
   endgenerate

   logic                 neg, is_zero, is_nar, special;
   logic [BW-1:0]        body;
   logic signed [RW-1:0] k_raw;
   logic [AW-1:0]        shamt;
   logic [ES-1:0]        e_raw;
   logic [FW:0]          f_raw;

   posit_sign_cond #(.NBITS(NBITS)) sign_i (
      .word_i (posit_i),
      .neg_o  (neg),
      .body_o (body),
      .zero_o (is_zero),
      .nar_o  (is_nar)
   );

   posit_regime_scan #(.NBITS(NBITS)) scan_i (
      .body_i   (body),
      .regime_o (k_raw),
      .shamt_o  (shamt)
   );

   posit_field_align #(.NBITS(NBITS), .ES(ES)) align_i (
      .tail_i  (body[BW-2:0]),
      .shamt_i (shamt),
      .exp_o   (e_raw),
      .frac_o  (f_raw)
   );

   assign special  = is_zero || is_nar;
   assign sign_o   = neg;
   assign zero_o   = is_zero;
   assign nar_o    = is_nar;
   assign regime_o = special ? '0 : k_raw;
   assign exp_o    = special ? '0 : e_raw;
   assign scale_o  = special ? '0 : $signed({k_raw, e_raw});
   assign frac_o   = special ? '0 : f_raw;
endmodule

// File: rtl/posit_field_decode_chk.sv
`timescale 1ns/1ps
module posit_field_decode_chk
   import posit_dec_pkg::*;
#(
   parameter int NBITS = 8,
   parameter int ES    = 1
) (
   input logic [NBITS-1:0]                    posit_i,
   input logic                                sign_i,
   input logic                                zero_i,
   input logic                                nar_i,
   input logic signed [regime_w(NBITS)-1:0]   regime_i,
   input logic [ES-1:0]                       exp_i,
   input logic signed [scale_w(NBITS,ES)-1:0] scale_i,
   input logic [frac_w(NBITS,ES):0]           frac_i
);
   always_comb begin
      AST_FLAGS_EXCLUSIVE: assert (!(zero_i && nar_i)); // R2
      if (zero_i)
         AST_ZERO_CLEAN: assert (!sign_i && scale_i == '0 && frac_i == '0 && posit_i == '0); // R1
      if (nar_i)
         AST_NAR_CLEAN: assert (sign_i && regime_i == '0 && frac_i == '0); // R2
      if (!zero_i && !nar_i)
         AST_REGIME_RANGE: assert (int'(regime_i) >= -(NBITS - 1) && int'(regime_i) <= NBITS - 2); // R4
      if (!zero_i && !nar_i)
         AST_SCALE_SPLIT: assert (int'(scale_i) == int'(regime_i) * (1 << ES) + int'(exp_i)); // R6
   end
endmodule

bind posit_field_decode posit_field_decode_chk #(.NBITS(NBITS), .ES(ES)) chk_i (
   .posit_i  (posit_i),
   .sign_i   (sign_o),
   .zero_i   (zero_o),
   .nar_i    (nar_o),
   .regime_i (regime_o),
   .exp_i    (exp_o),
   .scale_i  (scale_o),
   .frac_i   (frac_o)
);

// File: tb/posit_field_decode_tb.sv
`timescale 1ns/1ps
module posit_field_decode_tb_top;
   localparam int NB = 8;
   localparam int EB = 1;
   localparam int NV = 15;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  posit_i = '0;
   logic        sign_o, zero_o, nar_o;
   logic signed [3:0] regime_o;
   logic [0:0]  exp_o;
   logic signed [4:0] scale_o;
   logic [4:0]  frac_o;
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   posit_field_decode #(.NBITS(NB), .ES(EB)) dut_i (
      .posit_i (posit_i), .sign_o (sign_o), .zero_o (zero_o), .nar_o (nar_o),
      .regime_o (regime_o), .exp_o (exp_o), .scale_o (scale_o), .frac_o (frac_o)
   );

   // {word, sign, zero, nar, regime[4], exp[1], scale[5], frac[5]}
   localparam logic [25:0] VEC [NV] = '{
      {8'h00, 1'b0, 1'b1, 1'b0, 4'(0),  1'b0, 5'(0),   5'h00},
      {8'h80, 1'b1, 1'b0, 1'b1, 4'(0),  1'b0, 5'(0),   5'h00},
      {8'h40, 1'b0, 1'b0, 1'b0, 4'(0),  1'b0, 5'(0),   5'h10},
      {8'h50, 1'b0, 1'b0, 1'b0, 4'(0),  1'b1, 5'(1),   5'h10},
      {8'h01, 1'b0, 1'b0, 1'b0, 4'(-6), 1'b0, 5'(-12), 5'h10},
      {8'h7F, 1'b0, 1'b0, 1'b0, 4'(6),  1'b0, 5'(12),  5'h10},
      {8'h7E, 1'b0, 1'b0, 1'b0, 4'(5),  1'b0, 5'(10),  5'h10},
      {8'h3F, 1'b0, 1'b0, 1'b0, 4'(-1), 1'b1, 5'(-1),  5'h1F},
      {8'h6B, 1'b0, 1'b0, 1'b0, 4'(1),  1'b1, 5'(3),   5'h16},
      {8'hC0, 1'b1, 1'b0, 1'b0, 4'(0),  1'b0, 5'(0),   5'h10},
      {8'hFF, 1'b1, 1'b0, 1'b0, 4'(-6), 1'b0, 5'(-12), 5'h10},
      {8'h81, 1'b1, 1'b0, 1'b0, 4'(6),  1'b0, 5'(12),  5'h10},
      {8'hB5, 1'b1, 1'b0, 1'b0, 4'(0),  1'b0, 5'(0),   5'h1B},
      {8'h12, 1'b0, 1'b0, 1'b0, 4'(-2), 1'b0, 5'(-4),  5'h14},
      {8'h07, 1'b0, 1'b0, 1'b0, 4'(-4), 1'b1, 5'(-7),  5'h18}
   };

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (word %02h)", tag, act, exp, posit_i);
      end
   endtask

   task automatic apply(input logic [7:0] w);
      @(posedge clk);
      posit_i = w;
      @(negedge clk);
   endtask

   initial begin
      // reset state: word held at zero during bench reset
      repeat (3) @(negedge clk);
      check("R1 zero flag at reset", int'(zero_o), 1);
      check("R2 nar flag at reset", int'(nar_o), 0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][25:18]);
         check("R3 sign",   int'(sign_o),   int'(VEC[i][17]));
         check("R1 zero",   int'(zero_o),   int'(VEC[i][16]));
         check("R2 nar",    int'(nar_o),    int'(VEC[i][15]));
         check("R4 regime", int'(regime_o), int'($signed(VEC[i][14:11])));
         check("R5 exp",    int'(exp_o),    int'(VEC[i][10]));
         check("R6 scale",  int'(scale_o),  int'($signed(VEC[i][9:5])));
         check("R7 frac",   int'(frac_o),   int'(VEC[i][4:0]));
      end

      // exhaustive flags and hidden one
      for (int v = 0; v < 256; v++) begin
         apply(8'(v));
         check("R1 zero sweep", int'(zero_o), (v == 0) ? 1 : 0);
         check("R2 nar sweep",  int'(nar_o),  (v == 128) ? 1 : 0);
         if (v != 0 && v != 128) check("R7 hidden one", int'(frac_o[4]), 1);
      end

      // negation symmetry
      for (int v = 1; v < 128; v++) begin
         int pk, pe, ps, pf;
         apply(8'(v));
         pk = int'(regime_o); pe = int'(exp_o); ps = int'(scale_o); pf = int'(frac_o);
         apply(8'(-v));
         check("R3 neg sign",   int'(sign_o),   1);
         check("R3 neg regime", int'(regime_o), pk);
         check("R3 neg exp",    int'(exp_o),    pe);
         check("R3 neg scale",  int'(scale_o),  ps);
         check("R3 neg frac",   int'(frac_o),   pf);
      end

      // extreme regimes: run reaching word end, exponent cut off
      apply(8'h7F);
      check("R5 exp cut at maxpos", int'(exp_o), 0);
      check("R4 regime at maxpos", int'(regime_o), 6);
      apply(8'h02);
      check("R5 exp after long zero run", int'(exp_o), 0);
      check("R6 scale after long zero run", int'(scale_o), -10);
      apply(8'h03);
      check("R5 exp bit present", int'(exp_o), 1);
      check("R6 scale with exp", int'(scale_o), -9);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog all requirements actual=timeout expected=completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule